// File: doc/BRIEF.md
# Multimode Test Register

This block is an N-bit register whose one chain of flip-flops takes four roles, picked by two control bits. As an ordinary register it captures a parallel word on every clock. As a scan register it moves a serial stream from a scan input toward a scan output. As an autonomous pattern source it runs a linear feedback shift register (LFSR) that produces pseudo-random stimulus for a logic block downstream. As a response compactor it folds an N-bit parallel response into a running signature.

In a self-test setup, one instance feeds the logic under test and another collects its responses. A controller outside this block seeds both instances and sets their modes. It later scans the signature out and compares it with a known-good value. The head of the chain has a selector that chooses between the serial input and the feedback term. The feedback taps are a parameter mask.

Top module: `multimode_test_reg`

## Requirements
- R1: While `rstN` is low, every stage is 0 and `scanOut` is 0. Reset acts asynchronously.
- R2: With `capture`=1 and `feedback`=0 (code 10), each clock copies `parIn` into `stateQ`.
- R3: With `capture`=0 and `feedback`=0 (code 00), each clock loads stage 0 from `scanIn` and moves stage i-1 into stage i. `parIn` has no effect.
- R4: `scanOut` always equals the highest stage, `stateQ[WIDTH-1]`. In shift mode, a bit applied at `scanIn` appears at `scanOut` after exactly WIDTH clocks.
- R5: With `capture`=0 and `feedback`=1 (code 01), each clock loads stage 0 with the XOR of the stages selected by `FB_MASK` and moves stage i-1 into stage i. `parIn` and `scanIn` have no effect. The default mask 4'b1001 taps stages 0 and 3, which gives characteristic polynomial x^4+x^3+1.
- R6: With the default parameters and a nonzero seed, generation mode returns to the seed after exactly 15 clocks and never passes through zero.
- R7: In generation mode, an all-zero state stays at zero. A nonzero seed must first come in through load or scan.
- R8: With `capture`=1 and `feedback`=1 (code 11), each clock sets stage 0 to the feedback XOR `parIn[0]` and sets stage i to stage i-1 XOR `parIn[i]`. `scanIn` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| capture | input | 1 | Mode bit: selects parallel input usage (load or compaction) |
| feedback | input | 1 | Mode bit: selects feedback at the chain head (generation or compaction) |
| parIn | input | WIDTH | Parallel data or response word |
| scanIn | input | 1 | Serial input to stage 0 in shift mode |
| stateQ | output | WIDTH | Register contents |
| scanOut | output | 1 | Highest stage of the chain |

## Verification
A walked vector sequence moves between all four codes without resets in between. This catches a stage that takes the wrong source when the mode changes. The sequence also drives `parIn` and `scanIn` with values that would change the result if either leaked into a mode that must ignore it. Compaction steps use both an all-zero and an all-one response, which separates the feedback contribution from the parallel-input contribution. A full 15-clock generation run tells a correct maximal-length tap set from a wrong one. A zero-seed run confirms the lock-up state, and a scan-latency run pins the chain length seen at `scanOut`.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  // Mode code is {capture, feedback}
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_GEN   = 2'b01,
    MODE_LOAD  = 2'b10,
    MODE_COMP  = 2'b11
  } mtrMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic useFeedback;   // chain head takes feedback instead of scanIn
    logic mixParallel;   // XOR parallel input into every stage
    logic loadParallel;  // stages take parallel input directly
  } mtrStrobe_t;

endpackage

// File: rtl/mtr_ctrl.sv
module mtr_ctrl
  import mtr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       capture,
  input  logic       feedback,
  output mtrStrobe_t strobe
);

  mtrMode_t mode;

  assign mode = mtrMode_t'({capture, feedback});

  always_comb begin
    strobe = '0;
    unique case (mode)
      MODE_SHIFT: strobe = '0;
      MODE_GEN:   strobe.useFeedback = 1'b1;
      MODE_LOAD:  strobe.loadParallel = 1'b1;
      MODE_COMP: begin
        strobe.useFeedback = 1'b1;
        strobe.mixParallel = 1'b1;
      end
      default:    strobe = '0;
    endcase
  end

  // R2
  load_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadParallel |-> !strobe.useFeedback && !strobe.mixParallel);

  // R8
  mix_needs_fb_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mixParallel |-> strobe.useFeedback);

endmodule

// File: rtl/mtr_fb.sv
module mtr_fb #(
  parameter int                 WIDTH   = 4,
  parameter logic [WIDTH-1:0]   FB_MASK = 4'b1001
) (
  input  logic [WIDTH-1:0] stateQ,
  output logic             fbBit
);

  logic [WIDTH-1:0] tapped;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : gTap
      if (FB_MASK[g]) begin : gOn
        assign tapped[g] = stateQ[g];
      end else begin : gOff
        assign tapped[g] = 1'b0;
      end
    end
  endgenerate

  assign fbBit = ^tapped;

endmodule

// File: rtl/mtr_path.sv
module mtr_path
  import mtr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  mtrStrobe_t       strobe,
  input  logic [WIDTH-1:0] parIn,
  input  logic             scanIn,
  input  logic             fbBit,
  output logic [WIDTH-1:0] stateQ
);

  logic [WIDTH-1:0] nextQ;
  logic [WIDTH-1:0] mixVec;
  logic             headBit;

  assign mixVec  = strobe.mixParallel ? parIn : '0;
  assign headBit = (strobe.useFeedback ? fbBit : scanIn) ^ mixVec[0];

  assign nextQ[0] = strobe.loadParallel ? parIn[0] : headBit;

  genvar g;
  generate
    for (g = 1; g < WIDTH; g++) begin : gStage
      assign nextQ[g] = strobe.loadParallel ? parIn[g] : (stateQ[g-1] ^ mixVec[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= nextQ;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> stateQ == '0);

  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadParallel |=> stateQ == $past(parIn));

  // R3
  shift_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> stateQ == {$past(stateQ[WIDTH-2:0]), $past(scanIn)});

  // R7
  gen_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.useFeedback && !strobe.mixParallel && stateQ == '0) |=> stateQ == '0);

  // R8
  comp_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mixParallel |=>
      stateQ[WIDTH-1:1] == ($past(stateQ[WIDTH-2:0]) ^ $past(parIn[WIDTH-1:1])));

endmodule

// File: rtl/multimode_test_reg.sv
module multimode_test_reg
  import mtr_pkg::*;
#(
  parameter int               WIDTH   = 4,
  parameter logic [WIDTH-1:0] FB_MASK = 4'b1001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capture,
  input  logic             feedback,
  input  logic [WIDTH-1:0] parIn,
  input  logic             scanIn,
  output logic [WIDTH-1:0] stateQ,
  output logic             scanOut
);

  mtrStrobe_t strobe;
  logic       fbBit;

  mtr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .capture  (capture),
    .feedback (feedback),
    .strobe   (strobe)
  );

  mtr_fb #(.WIDTH(WIDTH), .FB_MASK(FB_MASK)) u_fb (
    .stateQ (stateQ),
    .fbBit  (fbBit)
  );

  mtr_path #(.WIDTH(WIDTH)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .parIn  (parIn),
    .scanIn (scanIn),
    .fbBit  (fbBit),
    .stateQ (stateQ)
  );

  assign scanOut = stateQ[WIDTH-1];

  // R4
  scan_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanOut == stateQ[WIDTH-1]);

  // R5
  gen_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!capture && feedback) |=> stateQ[0] == ^($past(stateQ) & FB_MASK));

endmodule

// File: tb/sim_multimode_test_reg.sv
module sim_multimode_test_reg;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         capture = 1'b0;
  logic         feedback = 1'b0;
  logic [W-1:0] parIn = '0;
  logic         scanIn = 1'b0;
  logic [W-1:0] stateQ;
  logic         scanOut;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  multimode_test_reg #(.WIDTH(W), .FB_MASK(4'b1001)) u0 (
    .clk(clk), .rstN(rstN), .capture(capture), .feedback(feedback),
    .parIn(parIn), .scanIn(scanIn), .stateQ(stateQ), .scanOut(scanOut)
  );

  // {mode[1:0], parIn[3:0], scanIn, expected stateQ[3:0]}
  localparam logic [10:0] VEC [0:13] = '{
    {2'b10, 4'b0001, 1'b0, 4'b0001},
    {2'b01, 4'b1111, 1'b1, 4'b0011},
    {2'b01, 4'b1111, 1'b1, 4'b0111},
    {2'b11, 4'b0101, 1'b0, 4'b1010},
    {2'b11, 4'b0000, 1'b1, 4'b0101},
    {2'b00, 4'b1111, 1'b1, 4'b1011},
    {2'b00, 4'b1111, 1'b0, 4'b0110},
    {2'b10, 4'b1111, 1'b0, 4'b1111},
    {2'b01, 4'b0000, 1'b1, 4'b1110},
    {2'b11, 4'b1111, 1'b0, 4'b0010},
    {2'b10, 4'b0000, 1'b0, 4'b0000},
    {2'b01, 4'b1111, 1'b1, 4'b0000},
    {2'b11, 4'b1000, 1'b0, 4'b1000},
    {2'b01, 4'b1111, 1'b0, 4'b0001}
  };

  function automatic string reqOf(input logic [1:0] m, input logic [W-1:0] e);
    case (m)
      2'b00:   return "R3";
      2'b01:   return (e == '0) ? "R7" : "R5";
      2'b10:   return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [W-1:0] z, input logic si);
    {capture, feedback} = m;
    parIn  = z;
    scanIn = si;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    @(posedge clk); @(posedge clk); #1;
    check("R1", stateQ, '0);
    check("R1", {3'b0, scanOut}, '0);
    rstN = 1'b1;

    // Vector walk, modes mixed without resets
    for (int i = 0; i < 14; i++) begin
      step(VEC[i][10:9], VEC[i][8:5], VEC[i][4]);
      check(reqOf(VEC[i][10:9], VEC[i][3:0]), stateQ, VEC[i][3:0]);
      check("R4", {3'b0, scanOut}, {3'b0, VEC[i][3]});
    end

    // R4: scan latency equals chain length
    step(2'b10, 4'b0000, 1'b0);
    for (int k = 1; k <= W; k++) begin
      step(2'b00, 4'b1111, (k == 1));
      check("R4", {3'b0, scanOut}, {3'b0, (k == W)});
    end

    // R6: full period from seed 0001, never zero
    step(2'b10, 4'b0001, 1'b0);
    begin
      int period = 0;
      bit sawZero = 0;
      for (int k = 1; k <= 20; k++) begin
        step(2'b01, 4'b1010, 1'b1);
        if (stateQ == '0) sawZero = 1;
        if (stateQ == 4'b0001 && period == 0) period = k;
      end
      check("R6", period[W-1:0], 4'd15);
      check("R6", {3'b0, sawZero}, '0);
    end

    // R7: zero seed in generation mode stays zero for many clocks
    step(2'b10, 4'b0000, 1'b0);
    for (int k = 0; k < 6; k++) step(2'b01, 4'b1111, 1'b1);
    check("R7", stateQ, '0);

    // R1: asynchronous reset in mid run
    step(2'b10, 4'b1101, 1'b0);
    #1 rstN = 1'b0;
    #0.5;
    check("R1", stateQ, '0);
    @(posedge clk); #1;
    check("R1", stateQ, '0);
    rstN = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule